// File: doc/BRIEF.md
# Synchronized Carrier Modulator

This block is a data-signal modulator. A modulation level chooses which of two carrier signals reaches the single output. A level of 1 selects the high-time carrier and a level of 0 selects the low-time carrier. Each carrier is taken from a bank of external carrier inputs through its own 4-bit source code. Each carrier also has its own invert control and its own switch-synchronization control.

When synchronization is enabled for the carrier currently in use, a request to change carriers is held back until that carrier shows a falling edge. The output therefore never shows a shortened pulse or a spur at the moment of the change. When synchronization is off, the change takes effect at once. Every carrier input and the modulation input pass through two-flop synchronizers. The edge detection and the switching state run in the system clock domain.

Software sets up the block through two 8-bit control words, one for each carrier. The high-carrier word also holds an output-disable bit that forces the output low.

Top module: `carmod_core`

## Requirements
- R1: Source code 0 makes a carrier a constant low. Codes 1 to 7 select carrier input bit `car_in[code-1]`. The code sits in bits 3..0 of that carrier's control word.
- R2: Source codes 8 to 15 connect no input, so the carrier is a constant low before any inversion.
- R3: With bit 6 (invert) of a carrier's control word set, that carrier is inverted after source selection. With bit 6 clear, it passes unchanged.
- R4: With synchronization off (bit 5 clear) for the carrier in use, a change of `mod_in` moves the output to the other carrier. It does so no later than the third rising clock edge after the change, whatever the carrier levels are.
- R5: With high-carrier synchronization on (bit 5 of word 0), a switch from the high carrier to the low carrier happens only after a falling edge of the high carrier as it appears after inversion.
- R6: With low-carrier synchronization on (bit 5 of word 1), a switch from the low carrier back to the high carrier happens only after a falling edge of the low carrier as it appears after inversion.
- R7: While bit 7 of word 0 (output disable) is 1, `mod_out` is 0. While it is 0, the output carries the modulated signal.
- R8: `reg_addr` selects the word: 0 for the high carrier and 1 for the low carrier. A write sets the word when `reg_wr` is high at a rising edge. Readback on `reg_rdata` is combinational. Bit 4 always reads 0, and bit 7 of word 1 always reads 0.
- R9: After reset both control words read 0, the effective modulation level is 0 and `mod_out` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Write strobe for the control words |
| reg_addr | input | 1 | Control word select: 0 for the high carrier, 1 for the low carrier |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Readback of the selected word |
| car_in | input | 7 | Asynchronous carrier inputs for source codes 1 to 7 |
| mod_in | input | 1 | Asynchronous modulation level |
| mod_out | output | 1 | Modulated output |

## Verification
Source selection is exercised with one-hot and inverted-one-hot input patterns on every code from 0 to 15. A wrong index or a reserved code that leaks an input shows up as a wrong output level.

In the unsynchronized case, the two carriers are given opposite levels, so an output that is late or stuck on one carrier is visible.

In the synchronized cases, the sequence is: hold the active carrier high, request the switch, drop the active carrier, then raise the other carrier. The output level at each step separates three behaviours: correctly holding back the switch, switching too early, and never switching.

// File: rtl/carmod_pkg.sv
package carmod_pkg;

  localparam int unsigned CW_W      = 8;
  localparam int unsigned SEL_W     = 4;
  localparam int unsigned BIT_DIS   = 7;
  localparam int unsigned BIT_INV   = 6;
  localparam int unsigned BIT_SYNC  = 5;
  localparam int unsigned BIT_GAP   = 4;

  typedef struct packed {
    logic             inv;
    logic             sync;
    logic [SEL_W-1:0] src;
  } car_cfg_t;

  // Pack one carrier configuration into its control-word layout.
  function automatic logic [CW_W-1:0] cfg_to_word(input car_cfg_t c, input logic top_bit);
    logic [CW_W-1:0] w;
    w           = '0;
    w[BIT_DIS]  = top_bit;
    w[BIT_INV]  = c.inv;
    w[BIT_SYNC] = c.sync;
    w[SEL_W-1:0] = c.src;
    return w;
  endfunction

  // Unpack the carrier fields of a control word.
  function automatic car_cfg_t word_to_cfg(input logic [CW_W-1:0] w);
    car_cfg_t c;
    c.inv  = w[BIT_INV];
    c.sync = w[BIT_SYNC];
    c.src  = w[SEL_W-1:0];
    return c;
  endfunction

  // Combine the two carriers under the effective level and the disable.
  function automatic logic carrier_mix(input logic hi, input logic lo,
                                       input logic lvl, input logic dis);
    return ~dis & ((hi & lvl) | (lo & ~lvl));
  endfunction

endpackage

// File: rtl/carmod_sync.sv
module carmod_sync #(
  parameter int unsigned WIDTH  = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_async,
  output logic [WIDTH-1:0] q_sync
);

  logic [WIDTH-1:0] chain [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[s] <= '0;
          else        chain[s] <= d_async;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[s] <= '0;
          else        chain[s] <= chain[s-1];
        end
      end
    end
  endgenerate

  assign q_sync = chain[STAGES-1];

endmodule

// File: rtl/carmod_src_sel.sv
module carmod_src_sel
  import carmod_pkg::*;
#(
  parameter int unsigned NUM_SRC = 7
) (
  input  logic               clk,
  input  logic               rst_n,
  input  car_cfg_t           cfg,
  input  logic [NUM_SRC-1:0] srcs,
  output logic               car
);

  localparam int unsigned NUM_CODES = 1 << SEL_W;

  logic [NUM_CODES-1:0] code_tbl;
  logic                 car_raw;
  logic                 code_reserved;

  // Code 0 is ground, codes 1..NUM_SRC pick an input, the rest are ground.
  generate
    for (genvar i = 0; i < NUM_CODES; i++) begin : g_code
      if (i >= 1 && i <= NUM_SRC) begin : g_live
        assign code_tbl[i] = srcs[i-1];
      end else begin : g_gnd
        assign code_tbl[i] = 1'b0;
      end
    end
  endgenerate

  assign code_reserved = (int'(cfg.src) > NUM_SRC);
  assign car_raw       = code_tbl[cfg.src];
  assign car           = car_raw ^ cfg.inv;

  // R2
  reserved_gnd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    code_reserved |-> (car == cfg.inv));

  // R1
  zero_code_gnd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg.src == '0) |-> (car == cfg.inv));

endmodule

// File: rtl/carmod_switch.sv
module carmod_switch (
  input  logic clk,
  input  logic rst_n,
  input  logic hi_car,
  input  logic lo_car,
  input  logic hi_sync,
  input  logic lo_sync,
  input  logic mod_req,
  output logic eff_lvl,
  output logic hi_fall,
  output logic lo_fall,
  output logic hi_hold,
  output logic lo_hold
);

  logic hi_prev, lo_prev;
  logic eff_q, eff_d;
  logic want_lo, want_hi;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_prev <= 1'b0;
      lo_prev <= 1'b0;
    end else begin
      hi_prev <= hi_car;
      lo_prev <= lo_car;
    end
  end

  assign hi_fall = hi_prev & ~hi_car;
  assign lo_fall = lo_prev & ~lo_car;

  assign want_lo = eff_q & ~mod_req;
  assign want_hi = ~eff_q & mod_req;

  // A pending switch is held while sync is on and no edge has come.
  assign hi_hold = want_lo & hi_sync & ~hi_fall;
  assign lo_hold = want_hi & lo_sync & ~lo_fall;

  always_comb begin
    eff_d = eff_q;
    if (want_lo && !hi_hold) eff_d = 1'b0;
    if (want_hi && !lo_hold) eff_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) eff_q <= 1'b0;
    else        eff_q <= eff_d;
  end

  assign eff_lvl = eff_q;

  // R5
  hi_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (eff_q && hi_sync && !hi_fall) |=> eff_q);

  // R6
  lo_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!eff_q && lo_sync && !lo_fall) |=> !eff_q);

  // R4
  free_to_lo_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (eff_q && !hi_sync && !mod_req) |=> !eff_q);

  // R4
  free_to_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!eff_q && !lo_sync && mod_req) |=> eff_q);

  // R9
  rst_level_chk: assert property (@(posedge clk)
    !rst_n |-> !eff_q);

endmodule

// File: rtl/carmod_regs.sv
module carmod_regs
  import carmod_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr,
  input  logic            addr,
  input  logic [CW_W-1:0] wdata,
  output logic [CW_W-1:0] rdata,
  output car_cfg_t        hi_cfg,
  output car_cfg_t        lo_cfg,
  output logic            out_dis
);

  car_cfg_t hi_q, lo_q;
  logic     dis_q;
  logic     unused_gap;

  assign unused_gap = wdata[BIT_GAP];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q  <= '0;
      lo_q  <= '0;
      dis_q <= 1'b0;
    end else if (wr) begin
      if (!addr) begin
        hi_q  <= word_to_cfg(wdata);
        dis_q <= wdata[BIT_DIS];
      end else begin
        lo_q  <= word_to_cfg(wdata);
      end
    end
  end

  assign rdata   = addr ? cfg_to_word(lo_q, 1'b0) : cfg_to_word(hi_q, dis_q);
  assign hi_cfg  = hi_q;
  assign lo_cfg  = lo_q;
  assign out_dis = dis_q;

  // R8
  hi_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && !addr) |=> (hi_cfg.src == $past(wdata[SEL_W-1:0])) && (out_dis == $past(wdata[BIT_DIS])));

  // R8
  lo_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && addr) |=> (lo_cfg.src == $past(wdata[SEL_W-1:0])) && (lo_cfg.inv == $past(wdata[BIT_INV])));

endmodule

// File: rtl/carmod_core.sv
module carmod_core
  import carmod_pkg::*;
#(
  parameter int unsigned NUM_SRC     = 7,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_wr,
  input  logic               reg_addr,
  input  logic [CW_W-1:0]    reg_wdata,
  output logic [CW_W-1:0]    reg_rdata,
  input  logic [NUM_SRC-1:0] car_in,
  input  logic               mod_in,
  output logic               mod_out
);

  localparam int unsigned IN_W = NUM_SRC + 1;

  car_cfg_t           hi_cfg, lo_cfg;
  logic               out_dis;
  logic [IN_W-1:0]    in_sync;
  logic [NUM_SRC-1:0] car_s;
  logic               mod_s;
  logic               hi_car, lo_car;
  logic               eff_lvl;
  logic               hi_fall, lo_fall, hi_hold, lo_hold;

  carmod_regs u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr      (reg_wr),
    .addr    (reg_addr),
    .wdata   (reg_wdata),
    .rdata   (reg_rdata),
    .hi_cfg  (hi_cfg),
    .lo_cfg  (lo_cfg),
    .out_dis (out_dis)
  );

  carmod_sync #(.WIDTH(IN_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .d_async ({mod_in, car_in}),
    .q_sync  (in_sync)
  );

  assign car_s = in_sync[NUM_SRC-1:0];
  assign mod_s = in_sync[IN_W-1];

  carmod_src_sel #(.NUM_SRC(NUM_SRC)) u_hi_sel (
    .clk   (clk),
    .rst_n (rst_n),
    .cfg   (hi_cfg),
    .srcs  (car_s),
    .car   (hi_car)
  );

  carmod_src_sel #(.NUM_SRC(NUM_SRC)) u_lo_sel (
    .clk   (clk),
    .rst_n (rst_n),
    .cfg   (lo_cfg),
    .srcs  (car_s),
    .car   (lo_car)
  );

  carmod_switch u_switch (
    .clk     (clk),
    .rst_n   (rst_n),
    .hi_car  (hi_car),
    .lo_car  (lo_car),
    .hi_sync (hi_cfg.sync),
    .lo_sync (lo_cfg.sync),
    .mod_req (mod_s),
    .eff_lvl (eff_lvl),
    .hi_fall (hi_fall),
    .lo_fall (lo_fall),
    .hi_hold (hi_hold),
    .lo_hold (lo_hold)
  );

  assign mod_out = carrier_mix(hi_car, lo_car, eff_lvl, out_dis);

  // R7
  dis_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_dis |-> !mod_out);

  // R5
  hold_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({hi_hold, lo_hold}));

  // R9
  rst_out_chk: assert property (@(posedge clk)
    !rst_n |-> (!mod_out && reg_rdata == '0));

endmodule

// File: tb/carmod_core_test.sv
`timescale 1ns/1ps
module carmod_core_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b1;
  logic       reg_wr = 1'b0;
  logic       reg_addr = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic [6:0] car_in = '0;
  logic       mod_in = 1'b0;
  logic       mod_out;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  carmod_core uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .car_in    (car_in),
    .mod_in    (mod_in),
    .mod_out   (mod_out)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic settle(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr_word(input logic a, input logic [7:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd_word(input logic a, output logic [7:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  // Word layout: [7] disable (word 0), [6] invert, [5] sync, [3:0] source.
  function automatic logic [7:0] word(input logic dis, input logic inv,
                                      input logic syn, input logic [3:0] src);
    return {dis, inv, syn, 1'b0, src};
  endfunction

  task automatic t_reset();
    logic [7:0] d;
    chk("R9 out", {7'd0, mod_out}, 8'h00);
    rd_word(1'b0, d); chk("R9 word0", d, 8'h00);
    rd_word(1'b1, d); chk("R9 word1", d, 8'h00);
  endtask

  task automatic t_regs();
    logic [7:0] d;
    wr_word(1'b0, 8'hFF); rd_word(1'b0, d); chk("R8 word0 bit4 zero", d, 8'hEF);
    wr_word(1'b1, 8'hFF); rd_word(1'b1, d); chk("R8 word1 bits7,4 zero", d, 8'h6F);
    wr_word(1'b0, 8'h00); wr_word(1'b1, 8'h00);
    rd_word(1'b0, d); chk("R8 word0 cleared", d, 8'h00);
  endtask

  task automatic t_select();
    mod_in = 1'b1;
    for (int k = 1; k <= 7; k++) begin
      wr_word(1'b0, word(0, 0, 0, 4'(k)));
      car_in = 7'(1 << (k - 1)); settle(4);
      chk($sformatf("R1 code %0d one-hot", k), {7'd0, mod_out}, 8'h01);
      car_in = ~7'(1 << (k - 1)); settle(4);
      chk($sformatf("R1 code %0d others", k), {7'd0, mod_out}, 8'h00);
    end
    wr_word(1'b0, word(0, 0, 0, 4'd0));
    car_in = 7'h7F; settle(4);
    chk("R1 code 0 ground", {7'd0, mod_out}, 8'h00);
  endtask

  task automatic t_reserved();
    mod_in = 1'b1; car_in = 7'h7F;
    for (int k = 8; k <= 15; k++) begin
      wr_word(1'b0, word(0, 0, 0, 4'(k)));
      settle(4);
      chk($sformatf("R2 code %0d", k), {7'd0, mod_out}, 8'h00);
    end
  endtask

  task automatic t_polarity();
    mod_in = 1'b1;
    wr_word(1'b0, word(0, 1, 0, 4'd1));
    car_in = 7'h00; settle(4); chk("R3 hi inverted low", {7'd0, mod_out}, 8'h01);
    car_in = 7'h01; settle(4); chk("R3 hi inverted high", {7'd0, mod_out}, 8'h00);
    mod_in = 1'b0;
    wr_word(1'b1, word(0, 1, 0, 4'd9));
    settle(4); chk("R3 lo inverted reserved", {7'd0, mod_out}, 8'h01);
    wr_word(1'b1, word(0, 0, 0, 4'd2));
    car_in = 7'h02; settle(4); chk("R3 lo plain", {7'd0, mod_out}, 8'h01);
  endtask

  task automatic t_nosync();
    wr_word(1'b0, word(0, 0, 0, 4'd1));
    wr_word(1'b1, word(0, 0, 0, 4'd2));
    car_in = 7'h01;
    mod_in = 1'b1; settle(3); chk("R4 to hi", {7'd0, mod_out}, 8'h01);
    mod_in = 1'b0; settle(3); chk("R4 to lo", {7'd0, mod_out}, 8'h00);
    car_in = 7'h02; settle(3); chk("R4 lo follows", {7'd0, mod_out}, 8'h01);
    mod_in = 1'b1; settle(3); chk("R4 back to hi", {7'd0, mod_out}, 8'h00);
  endtask

  task automatic t_hisync();
    wr_word(1'b0, word(0, 0, 1, 4'd1));
    wr_word(1'b1, word(0, 0, 0, 4'd2));
    car_in = 7'h01; mod_in = 1'b1; settle(5);
    chk("R5 on hi", {7'd0, mod_out}, 8'h01);
    mod_in = 1'b0; settle(8);
    chk("R5 held on hi", {7'd0, mod_out}, 8'h01);
    car_in = 7'h00; settle(5);
    chk("R5 hi dropped", {7'd0, mod_out}, 8'h00);
    car_in = 7'h02; settle(5);
    chk("R5 switched to lo", {7'd0, mod_out}, 8'h01);
  endtask

  task automatic t_losync();
    wr_word(1'b0, word(0, 0, 0, 4'd1));
    wr_word(1'b1, word(0, 0, 1, 4'd2));
    car_in = 7'h02; mod_in = 1'b0; settle(5);
    chk("R6 on lo", {7'd0, mod_out}, 8'h01);
    mod_in = 1'b1; settle(8);
    chk("R6 held on lo", {7'd0, mod_out}, 8'h01);
    car_in = 7'h00; settle(5);
    chk("R6 lo dropped", {7'd0, mod_out}, 8'h00);
    car_in = 7'h01; settle(5);
    chk("R6 switched to hi", {7'd0, mod_out}, 8'h01);
  endtask

  task automatic t_disable();
    wr_word(1'b0, word(0, 0, 0, 4'd3));
    car_in = 7'h04; mod_in = 1'b1; settle(5);
    chk("R7 enabled", {7'd0, mod_out}, 8'h01);
    wr_word(1'b0, word(1, 0, 0, 4'd3)); settle(1);
    chk("R7 disabled", {7'd0, mod_out}, 8'h00);
    wr_word(1'b0, word(0, 0, 0, 4'd3)); settle(1);
    chk("R7 re-enabled", {7'd0, mod_out}, 8'h01);
  endtask

  initial begin
    #1 rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    settle(2);
    t_reset();
    t_regs();
    t_select();
    t_reserved();
    t_polarity();
    t_nosync();
    t_hisync();
    t_losync();
    t_disable();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule